// File: doc/BRIEF.md
# PFC Link Fault Protection Supervisor

This block guards the boost switch of a power-factor-correction stage. On each ADC sample strobe it reads three unsigned codes: the link-sense current (output voltage), the line-sense current (rectified input), and the rectified-line peak. From these it decides whether the switch drive may run. It also computes the longest on-time the switch may use in the next cycle.

Two faults stop the drive. The first is an overvoltage trip. It fires at once when the link code rises above 105 % of a reference code, and it releases only after the link code falls below the trip code less a hysteresis step. The second is a loss-of-feedback fault. It fires when the link reading falls under the line reading. It clears only when the link reading is at or above the line reading and also above the line peak.

The on-time ceiling is a constant divided by the line code. It is clamped to a fixed count when the line code is small. Each fault also sets a sticky status bit, which a read pulse clears. All decisions are registered on the strobe, so the drive enable moves only on sample boundaries.

Top module: `pfc_guard`

## Requirements
- R1: After reset, and until the first strobe, `gate_en`, `ovp_flag`, `olp_flag`, `ovp_seen` and `olp_seen` are 0 and `ton_max` is 0.
- R2: A strobe with `link_code` strictly above OVP_TRIP = REF_CODE*105/100 (default 840) sets `ovp_flag` in the following cycle.
- R3: While `ovp_flag` is set, a strobe with `link_code` between OVP_TRIP-HYST_CODE (default 831) and OVP_TRIP, both inclusive, keeps it set. A strobe with `link_code` below that release code clears it.
- R4: A strobe with `link_code` < `line_code` sets `olp_flag` in the following cycle.
- R5: While `olp_flag` is set, it clears only on a strobe where `link_code` >= `line_code` and `link_code` > `line_pk_code`. Otherwise it stays set.
- R6: On each strobe, `ton_max` becomes TON_CAP (default 2000) when `line_code` < LINE_FLOOR (default 32). Otherwise it becomes min(TON_CAP, floor(TON_NUM / `line_code`)), with TON_NUM defaulting to 60000.
- R7: `gate_en` is 1 exactly when at least one strobe has been taken and neither fault flag is set. Cycles without a strobe leave `gate_en` and `ton_max` unchanged, whatever the input codes are.
- R8: `ovp_seen` and `olp_seen` are set together with their fault flag and stay set after the fault clears. A `stat_rd` pulse clears them, unless the fault is present in that same cycle, in which case the bit stays set.
- R9: A strobe with `link_code` exactly equal to OVP_TRIP does not trip overvoltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe; codes are valid when high |
| link_code | input | ADC_W | Link-sense current code |
| line_code | input | ADC_W | Line-sense current code |
| line_pk_code | input | ADC_W | Rectified-line peak code |
| stat_rd | input | 1 | Read pulse that clears sticky status |
| gate_en | output | 1 | Switch drive enable |
| ton_max | output | TON_W | On-time ceiling in clock counts |
| ovp_flag | output | 1 | Overvoltage fault active |
| olp_flag | output | 1 | Loss-of-feedback fault active |
| ovp_seen | output | 1 | Sticky overvoltage status |
| olp_seen | output | 1 | Sticky loss-of-feedback status |

## Verification
The link code is walked across the overvoltage band: exactly at the trip code, one above it, at the release code, and one below it. This separates the strict trip compare from an inclusive one, and shows whether the release uses the hysteresis step or the trip code. For the loss-of-feedback fault, the link code is placed below the line code, then between the line code and the peak, then equal to the line code but above the peak. This shows that both recovery conditions are required. Line codes below, at and far above the floor exercise the clamp and the division. Unstrobed input changes and read pulses that coincide with a fault check the strobe gating and the rule that a set wins over a clear.

// File: rtl/pfc_guard_pkg.sv
package pfc_guard_pkg;

  // trip code at 105 % of the reference code
  function automatic int unsigned ovp_trip_of(input int unsigned ref_code);
    return (ref_code * 105) / 100;
  endfunction

  // on-time ceiling: constant over line code, clamped
  function automatic int unsigned ton_of(input int unsigned line,
                                         input int unsigned num,
                                         input int unsigned cap,
                                         input int unsigned floor_code);
    int unsigned q;
    if (line < floor_code) return cap;
    q = num / line;
    return (q > cap) ? cap : q;
  endfunction

endpackage

// File: rtl/pfc_ovp_det.sv
module pfc_ovp_det #(
  parameter int unsigned ADC_W    = 10,
  parameter int unsigned TRIP     = 840,
  parameter int unsigned RELEASE  = 831
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [ADC_W-1:0] link_code,
  output logic             ovp_nxt,
  output logic             ovp_flag
);
  localparam logic [ADC_W-1:0] TRIP_C = ADC_W'(TRIP);
  localparam logic [ADC_W-1:0] REL_C  = ADC_W'(RELEASE);

  logic above_trip, below_rel;
  assign above_trip = link_code > TRIP_C;
  assign below_rel  = link_code < REL_C;

  always_comb begin
    ovp_nxt = ovp_flag;
    if (smp_vld) begin
      if (above_trip)     ovp_nxt = 1'b1;
      else if (below_rel) ovp_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovp_flag <= 1'b0;
    else        ovp_flag <= ovp_nxt;
endmodule

// File: rtl/pfc_olp_det.sv
module pfc_olp_det #(
  parameter int unsigned ADC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [ADC_W-1:0] link_code,
  input  logic [ADC_W-1:0] line_code,
  input  logic [ADC_W-1:0] line_pk_code,
  output logic             olp_nxt,
  output logic             olp_flag
);
  logic link_low, link_ok;
  assign link_low = link_code < line_code;
  assign link_ok  = (link_code >= line_code) && (link_code > line_pk_code);

  always_comb begin
    olp_nxt = olp_flag;
    if (smp_vld) begin
      if (link_low)     olp_nxt = 1'b1;
      else if (link_ok) olp_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) olp_flag <= 1'b0;
    else        olp_flag <= olp_nxt;
endmodule

// File: rtl/pfc_ton_limit.sv
module pfc_ton_limit
  import pfc_guard_pkg::*;
#(
  parameter int unsigned ADC_W      = 10,
  parameter int unsigned TON_W      = 16,
  parameter int unsigned TON_NUM    = 60000,
  parameter int unsigned TON_CAP    = 2000,
  parameter int unsigned LINE_FLOOR = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [ADC_W-1:0] line_code,
  output logic [TON_W-1:0] ton_max
);
  logic [TON_W-1:0] ton_calc;
  assign ton_calc = TON_W'(ton_of(int'(line_code), TON_NUM, TON_CAP, LINE_FLOOR));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ton_max <= '0;
    else if (smp_vld) ton_max <= ton_calc;
endmodule

// File: rtl/pfc_guard.sv
module pfc_guard
  import pfc_guard_pkg::*;
#(
  parameter int unsigned ADC_W      = 10,
  parameter int unsigned TON_W      = 16,
  parameter int unsigned REF_CODE   = 800,
  parameter int unsigned HYST_CODE  = 9,
  parameter int unsigned TON_NUM    = 60000,
  parameter int unsigned TON_CAP    = 2000,
  parameter int unsigned LINE_FLOOR = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [ADC_W-1:0] link_code,
  input  logic [ADC_W-1:0] line_code,
  input  logic [ADC_W-1:0] line_pk_code,
  input  logic             stat_rd,
  output logic             gate_en,
  output logic [TON_W-1:0] ton_max,
  output logic             ovp_flag,
  output logic             olp_flag,
  output logic             ovp_seen,
  output logic             olp_seen
);
  localparam int unsigned OVP_TRIP = ovp_trip_of(REF_CODE);
  localparam int unsigned OVP_REL  = OVP_TRIP - HYST_CODE;
  localparam int unsigned N_FAULT  = 2;

  logic ovp_nxt, olp_nxt, primed;
  logic [N_FAULT-1:0] fault_nxt, seen_q;

  pfc_ovp_det #(.ADC_W(ADC_W), .TRIP(OVP_TRIP), .RELEASE(OVP_REL)) u_ovp (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .link_code(link_code),
    .ovp_nxt(ovp_nxt), .ovp_flag(ovp_flag));

  pfc_olp_det #(.ADC_W(ADC_W)) u_olp (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .link_code(link_code),
    .line_code(line_code), .line_pk_code(line_pk_code),
    .olp_nxt(olp_nxt), .olp_flag(olp_flag));

  pfc_ton_limit #(.ADC_W(ADC_W), .TON_W(TON_W), .TON_NUM(TON_NUM),
                  .TON_CAP(TON_CAP), .LINE_FLOOR(LINE_FLOOR)) u_ton (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .line_code(line_code),
    .ton_max(ton_max));

  assign fault_nxt = {olp_nxt, ovp_nxt};

  // sticky status: a fault in the same cycle wins over the read clear
  for (genvar i = 0; i < N_FAULT; i++) begin : g_seen
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) seen_q[i] <= 1'b0;
      else        seen_q[i] <= (seen_q[i] & ~stat_rd) | fault_nxt[i];
  end

  assign ovp_seen = seen_q[0];
  assign olp_seen = seen_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       primed <= 1'b0;
    else if (smp_vld) primed <= 1'b1;

  assign gate_en = primed & ~ovp_flag & ~olp_flag;
endmodule

// File: rtl/pfc_guard_chk.sv
module pfc_guard_chk
  import pfc_guard_pkg::*;
#(
  parameter int unsigned ADC_W     = 10,
  parameter int unsigned TON_W     = 16,
  parameter int unsigned REF_CODE  = 800,
  parameter int unsigned HYST_CODE = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_vld,
  input logic [ADC_W-1:0] link_code,
  input logic [ADC_W-1:0] line_code,
  input logic             gate_en,
  input logic [TON_W-1:0] ton_max,
  input logic             ovp_flag,
  input logic             olp_flag,
  input logic             ovp_seen,
  input logic             olp_seen
);
  localparam logic [ADC_W-1:0] TRIP_C = ADC_W'(ovp_trip_of(REF_CODE));
  localparam logic [ADC_W-1:0] REL_C  = ADC_W'(ovp_trip_of(REF_CODE) - HYST_CODE);

  // R2
  ovp_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (link_code > TRIP_C) |=> ovp_flag);

  // R3
  ovp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && ovp_flag && (link_code >= REL_C) && (link_code <= TRIP_C) |=> ovp_flag);

  // R3
  ovp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (link_code < REL_C) |=> !ovp_flag);

  // R4
  olp_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && (link_code < line_code) |=> olp_flag);

  // R7
  no_strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(gate_en) && $stable(ton_max));

  // R7
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_flag || olp_flag) |-> !gate_en);

  // R8
  sticky_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_flag |-> ovp_seen) and (olp_flag |-> olp_seen));
endmodule

bind pfc_guard pfc_guard_chk #(
  .ADC_W(ADC_W), .TON_W(TON_W), .REF_CODE(REF_CODE), .HYST_CODE(HYST_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .link_code(link_code),
  .line_code(line_code), .gate_en(gate_en), .ton_max(ton_max),
  .ovp_flag(ovp_flag), .olp_flag(olp_flag), .ovp_seen(ovp_seen),
  .olp_seen(olp_seen));

// File: tb/tb_pfc_guard.sv
module tb_pfc_guard;
  localparam int CLK_PERIOD = 10;
  localparam int TRIP = 840;
  localparam int REL  = 831;
  localparam int KNUM = 60000;
  localparam int CAP  = 2000;
  localparam int FLR  = 32;

  typedef struct {
    logic        gate, ovp, olp, sov, sol;
    int          ton;
    string       tag;
  } exp_t;

  logic clk = 0, rst_n = 0, smp_vld = 0, stat_rd = 0;
  logic [9:0] link_code = 0, line_code = 0, line_pk_code = 0;
  logic gate_en, ovp_flag, olp_flag, ovp_seen, olp_seen;
  logic [15:0] ton_max;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t q[$];

  logic m_ovp = 0, m_olp = 0, m_prim = 0, m_sov = 0, m_sol = 0;
  int   m_ton = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfc_guard dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .link_code(link_code),
    .line_code(line_code), .line_pk_code(line_pk_code), .stat_rd(stat_rd),
    .gate_en(gate_en), .ton_max(ton_max), .ovp_flag(ovp_flag),
    .olp_flag(olp_flag), .ovp_seen(ovp_seen), .olp_seen(olp_seen));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues what the ports must show after it
  task automatic step(input int lk, input int ln, input int pk,
                      input bit v, input bit r, input string tag);
    @(negedge clk);
    link_code = 10'(lk); line_code = 10'(ln); line_pk_code = 10'(pk);
    smp_vld = v; stat_rd = r;
    if (v) begin
      if (lk > TRIP) m_ovp = 1;
      else if (lk < REL) m_ovp = 0;
      if (lk < ln) m_olp = 1;
      else if (lk >= ln && lk > pk) m_olp = 0;
      if (ln < FLR) m_ton = CAP;
      else m_ton = (KNUM / ln > CAP) ? CAP : KNUM / ln;
      m_prim = 1;
    end
    m_sov = (m_sov & ~r) | m_ovp;
    m_sol = (m_sol & ~r) | m_olp;
    q.push_back('{gate: m_prim & ~m_ovp & ~m_olp, ovp: m_ovp, olp: m_olp,
                  sov: m_sov, sol: m_sol, ton: m_ton, tag: tag});
  endtask

  // monitor: samples shortly after each rising edge
  initial forever begin
    @(posedge clk); #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "gate_en",  int'(gate_en),  int'(e.gate));
      chk(e.tag, "ovp_flag", int'(ovp_flag), int'(e.ovp));
      chk(e.tag, "olp_flag", int'(olp_flag), int'(e.olp));
      chk(e.tag, "ovp_seen", int'(ovp_seen), int'(e.sov));
      chk(e.tag, "olp_seen", int'(olp_seen), int'(e.sol));
      chk(e.tag, "ton_max",  int'(ton_max),  e.ton);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "gate_en",  int'(gate_en), 0);
    chk("R1", "ovp_flag", int'(ovp_flag), 0);
    chk("R1", "olp_flag", int'(olp_flag), 0);
    chk("R1", "ovp_seen", int'(ovp_seen), 0);
    chk("R1", "olp_seen", int'(olp_seen), 0);
    chk("R1", "ton_max",  int'(ton_max), 0);

    step(700, 300, 500, 1, 0, "R6_R7 normal");
    step(TRIP, 300, 500, 1, 0, "R9 at trip");
    step(TRIP+1, 300, 500, 1, 0, "R2 trip");
    step(REL, 300, 500, 1, 0, "R3 hold at release code");
    step(REL-1, 300, 500, 1, 0, "R3 release");
    step(REL-1, 300, 500, 0, 1, "R8 read clears");
    step(900, 10, 500, 0, 0, "R7 no strobe ignored");
    step(200, 300, 400, 1, 0, "R4 olp trip");
    step(350, 300, 400, 1, 0, "R5 hold below peak");
    step(200, 300, 100, 0, 1, "R8 read with olp active");
    step(300, 300, 299, 1, 0, "R5 release");
    step(300, 20, 100, 1, 1, "R6 below floor");
    step(300, FLR, 100, 1, 0, "R6 at floor");
    step(1010, 1000, 100, 1, 0, "R6 high line");
    step(900, 300, 500, 1, 1, "R8 set wins over read");
    step(900, 300, 500, 0, 1, "R8 stays while active");
    step(500, 300, 400, 1, 0, "R3 drop out");
    step(500, 300, 400, 0, 1, "R8 clear after drop");
    step(500, 300, 400, 0, 0, "R7 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule